// File: doc/BRIEF.md
# Multi-Phase Output Delay Selector

This block shifts a single-bit signal in time with a resolution of one quarter of a 4 ns clock period. It does not rely on a fast serial pipeline. It uses four copies of a 250 MHz clock, each lagging the previous one by 1 ns. Each copy clocks one output flip-flop. The outputs of the four flip-flops are ORed to form the delayed signal. Only the flip-flop picked by the delay code receives data, and the other three are loaded with 0.

The input is sampled on the rising edge of phase 0. Whole 4 ns periods of delay come from a shift register clocked by phase 0. The sub-period step comes from which phase flip-flop is loaded. Data bound for phases 0 and 1 first goes through a retiming register on phase 2. As a result, every hop between clock phases has at least 2 ns of margin. The delay code is sampled only on phase-0 edges, so a code change always lands on a period boundary.

Top module: `multiphase_delay`

## Requirements
- R1: While `rst_n` is low, `dout` is 0. A pulse that is in flight when reset is asserted never appears on `dout` after reset is released.
- R2: Let T be the phase-0 rising edge at which `din` is sampled high. With `dly_code` = c, `dout` rises at T + 6 ns + c ns. Bits [3:2] of c add whole 4 ns periods and bits [1:0] add 1 ns steps. `dout` therefore rises on an edge of phase ((c[1:0] + 2) mod 4).
- R3: When `din` is sampled high on N consecutive phase-0 edges, `dout` stays high for exactly 4·N ns and then returns to 0.
- R4: Only the phase flip-flop selected by the code is loaded with data. `dout` is 0 at every point outside the delayed copy of the input.
- R5: `dly_code` is sampled only on phase-0 rising edges. A sample whose code has bits [3:2] = 0 uses the code present at the edge on which `din` is sampled. Changes to the code between edges, or after that edge, do not alter that sample's delay.
- R6: The adjustable range covers at least 8 ns. Code 8 delays the output by exactly 8 ns more than code 0, and code 15 delays it by 15 ns more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ph | input | 4 | Four 250 MHz clocks; bit i lags bit 0 by i ns |
| rst_n | input | 1 | Asynchronous active-low reset for all phase domains |
| din | input | 1 | Signal to delay, sampled on clk_ph[0] |
| dly_code | input | 4 | Delay code: [3:2] whole periods, [1:0] phase steps |
| dout | output | 1 | OR of the four phase flip-flops: the delayed signal |

## Verification
The main function is driven with a table of codes covering every phase step, several whole-period counts and the extreme codes 0 and 15. Each code is paired with pulse widths of one to three periods. Samples taken half a nanosecond on either side of the expected rising and falling edges separate a wrong phase choice (off by 1 ns) from a wrong period count (off by 4 ns) and from a stretched or shortened pulse. Directed cases toggle the code between edges and just after the sampling edge, which exposes a control path that samples at the wrong time. A reset asserted during a pulse in flight exposes state that survives reset.

// File: rtl/dly_pkg.sv
`timescale 1ns/100ps
package dly_pkg;
    // default geometry: 4 phases, up to 3 whole periods
    localparam int unsigned DEF_PH_W  = 2;
    localparam int unsigned DEF_CYC_W = 2;

    // maps a phase-step field to the index of the output flop that realises it
    function automatic int unsigned step_to_flop(input int unsigned step, input int unsigned nph);
        return (step + nph / 2) % nph;
    endfunction
endpackage

// File: rtl/dly_ctrl.sv
`timescale 1ns/100ps
module dly_ctrl #(
    parameter int unsigned PH_W  = dly_pkg::DEF_PH_W,
    parameter int unsigned CYC_W = dly_pkg::DEF_CYC_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    din,
    input  logic [PH_W+CYC_W-1:0]   dly_code,
    output logic                    tap_data,
    output logic [(1<<PH_W)-1:0]    tap_mask
);
    localparam int unsigned NPH    = 1 << PH_W;
    localparam int unsigned DEPTH  = 1 << CYC_W;
    localparam int unsigned CODE_W = PH_W + CYC_W;

    typedef struct packed {
        logic [DEPTH-1:0]  hist;
        logic [CODE_W-1:0] code;
        logic              data;
        logic [NPH-1:0]    mask;
        logic [1:0]        warm;
    } ctrl_t;

    ctrl_t s_d, s_q;

    logic [CYC_W-1:0] cyc_sel;
    logic [PH_W-1:0]  step_sel;

    always_comb begin
        s_d      = s_q;
        cyc_sel  = s_q.code[CODE_W-1:PH_W];
        step_sel = s_q.code[PH_W-1:0];
        s_d.hist = {s_q.hist[DEPTH-2:0], din};
        s_d.code = dly_code;
        s_d.data = s_q.hist[cyc_sel];
        s_d.mask = '0;
        for (int i = 0; i < NPH; i++) begin
            if (dly_pkg::step_to_flop(int'(step_sel), NPH) == i) begin
                s_d.mask[i] = 1'b1;
            end
        end
        if (s_q.warm != 2'd3) begin
            s_d.warm = s_q.warm + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tap_data = s_q.data;
    assign tap_mask = s_q.mask;

    AST_TAP_ZERO_PERIODS: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.warm == 2'd3 && s_q.code[CODE_W-1:PH_W] == '0) |=> (tap_data == $past(din, 2))); // R2
endmodule

// File: rtl/dly_retime.sv
`timescale 1ns/100ps
module dly_retime #(
    parameter int unsigned NPH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           data_i,
    input  logic [NPH-1:0] mask_i,
    output logic           data_o,
    output logic [NPH-1:0] mask_o
);
    typedef struct packed {
        logic           data;
        logic [NPH-1:0] mask;
    } rt_t;

    rt_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.data = data_i;
        s_d.mask = mask_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign data_o = s_q.data;
    assign mask_o = s_q.mask;
endmodule

// File: rtl/dly_phase_ff.sv
`timescale 1ns/100ps
module dly_phase_ff (
    input  logic clk,
    input  logic rst_n,
    input  logic data_i,
    input  logic sel_i,
    output logic q
);
    typedef struct packed {
        logic q;
    } pf_t;

    pf_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        s_d.q = sel_i ? data_i : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign q = s_q.q;

    AST_UNSEL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |=> !q); // R4
    AST_SEL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && data_i) |=> q); // R2
endmodule

// File: rtl/multiphase_delay.sv
`timescale 1ns/100ps
module multiphase_delay #(
    parameter int unsigned PH_W  = dly_pkg::DEF_PH_W,
    parameter int unsigned CYC_W = dly_pkg::DEF_CYC_W
) (
    input  logic [(1<<PH_W)-1:0]  clk_ph,
    input  logic                  rst_n,
    input  logic                  din,
    input  logic [PH_W+CYC_W-1:0] dly_code,
    output logic                  dout
);
    localparam int unsigned NPH      = 1 << PH_W;
    localparam int unsigned HALF     = NPH / 2;
    localparam int unsigned DEPTH    = 1 << CYC_W;
    localparam int unsigned IDLE_MAX = DEPTH + 2;
    localparam int unsigned IDLE_W   = $clog2(IDLE_MAX + 1);

    logic           tap_data, rt_data;
    logic [NPH-1:0] tap_mask, rt_mask;
    logic [NPH-1:0] q_ph;

    dly_ctrl #(.PH_W(PH_W), .CYC_W(CYC_W)) u_ctrl (
        .clk      (clk_ph[0]),
        .rst_n    (rst_n),
        .din      (din),
        .dly_code (dly_code),
        .tap_data (tap_data),
        .tap_mask (tap_mask)
    );

    // half-period retiming so the early phases never sample within 1 ns of a change
    dly_retime #(.NPH(NPH)) u_retime (
        .clk    (clk_ph[HALF]),
        .rst_n  (rst_n),
        .data_i (tap_data),
        .mask_i (tap_mask),
        .data_o (rt_data),
        .mask_o (rt_mask)
    );

    for (genvar i = 0; i < NPH; i++) begin : g_phase
        if (i < HALF) begin : g_late
            dly_phase_ff u_ff (
                .clk    (clk_ph[i]),
                .rst_n  (rst_n),
                .data_i (rt_data),
                .sel_i  (rt_mask[i]),
                .q      (q_ph[i])
            );
        end else begin : g_early
            dly_phase_ff u_ff (
                .clk    (clk_ph[i]),
                .rst_n  (rst_n),
                .data_i (tap_data),
                .sel_i  (tap_mask[i]),
                .q      (q_ph[i])
            );
        end
    end

    assign dout = |q_ph;

    // count of consecutive low input samples, used only by the check below
    logic [IDLE_W-1:0] idle_d, idle_q;

    always_comb begin
        idle_d = idle_q;
        if (din) begin
            idle_d = '0;
        end else if (idle_q != IDLE_W'(IDLE_MAX)) begin
            idle_d = idle_q + 1'b1;
        end
    end

    always_ff @(posedge clk_ph[0] or negedge rst_n) begin
        if (!rst_n) begin
            idle_q <= '0;
        end else begin
            idle_q <= idle_d;
        end
    end

    AST_QUIET_AFTER_IDLE: assert property (@(posedge clk_ph[0]) disable iff (!rst_n)
        (idle_q == IDLE_W'(IDLE_MAX)) |-> !dout); // R3
endmodule

// File: tb/multiphase_delay_tb.sv
`timescale 1ns/100ps
module multiphase_delay_tb;
    localparam int NPH    = 4;
    localparam int CODE_W = 4;

    logic ph0, ph1, ph2, ph3;
    logic [NPH-1:0]    clk_ph;
    logic              rst_n;
    logic              din;
    logic [CODE_W-1:0] dly_code;
    logic              dout;
    int total = 0;
    int bad   = 0;
    logic done = 1'b0;

    assign clk_ph = {ph3, ph2, ph1, ph0};

    multiphase_delay u_dut (
        .clk_ph   (clk_ph),
        .rst_n    (rst_n),
        .din      (din),
        .dly_code (dly_code),
        .dout     (dout)
    );

    // phase i rises at 2 + i + 4n ns
    initial begin ph0 = 0; forever #2 ph0 = ~ph0; end
    initial begin ph1 = 0; #1; forever #2 ph1 = ~ph1; end
    initial begin ph2 = 0; #2; forever #2 ph2 = ~ph2; end
    initial begin ph3 = 0; #3; forever #2 ph3 = ~ph3; end

    // {code[3:0], width in periods[3:0]}
    localparam logic [7:0] VEC [10] = '{
        8'h01, 8'h12, 8'h21, 8'h33, 8'h41,
        8'h71, 8'h82, 8'hB1, 8'hF1, 8'h52
    };

    task automatic chk(input logic exp, input string req);
        total++;
        if (dout !== exp) begin
            bad++;
            $display("FAIL %s at %0t: dout=%b expected=%b", req, $time, dout, exp);
        end
    endtask

    task automatic flush();
        din = 1'b0;
        repeat (8) @(posedge ph0);
        #0.5;
    endtask

    // pulse of w periods; edges expected at t0+6+code and 4*w later
    task automatic run_pulse(input logic [3:0] code, input int w, input string req);
        flush();
        dly_code = code;
        repeat (6) @(posedge ph0);
        #0.5 din = 1'b1;
        @(posedge ph0);
        fork
            begin
                repeat (w - 1) @(posedge ph0);
                #0.5 din = 1'b0;
            end
            begin
                #(5.5 + real'(code)) chk(1'b0, req);
                #1 chk(1'b1, req);
                #(4.0 * w - 1.0) chk(1'b1, req);
                #1 chk(1'b0, req);
            end
        join
    endtask

    initial begin
        rst_n    = 1'b0;
        din      = 1'b0;
        dly_code = '0;
        #7.3;
        chk(1'b0, "R1 reset state");
        din = 1'b1;
        #8 chk(1'b0, "R1 reset holds output low");
        din = 1'b0;
        rst_n = 1'b1;

        // table walk: R2 delay, R3 width, R4 quiet outside the pulse, R6 range
        for (int k = 0; k < 10; k++) begin
            run_pulse(VEC[k][7:4], int'(VEC[k][3:0]), "R2/R3/R4/R6 table");
        end

        // R5: code toggled between edges and right after the sampling edge
        flush();
        dly_code = 4'd1;
        repeat (6) @(posedge ph0);
        #0.5 din = 1'b1;
        #2 dly_code = 4'd3;
        #1 dly_code = 4'd1;
        @(posedge ph0);
        #0.5 din = 1'b0;
        dly_code = 4'd2;
        #6 chk(1'b0, "R5 before edge");
        #1 chk(1'b1, "R5 rise at code 1");
        #3 chk(1'b1, "R5 held");
        #1 chk(1'b0, "R5 fall at code 1");
        run_pulse(4'd2, 1, "R5 new code applies");

        // R1: reset during a pulse in flight (code 8, two periods)
        flush();
        dly_code = 4'd8;
        repeat (6) @(posedge ph0);
        #0.5 din = 1'b1;
        @(posedge ph0);
        #3.5 rst_n = 1'b0;
        din = 1'b0;
        #0.5 chk(1'b0, "R1 low after reset assert");
        #6.3 rst_n = 1'b1;
        #4.2 chk(1'b0, "R1 pulse discarded");
        #6 chk(1'b0, "R1 pulse discarded late");

        // R6 boundary again: code 0 and code 15 back to back
        run_pulse(4'd0, 1, "R6 minimum code");
        run_pulse(4'd15, 2, "R6 maximum code");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired: done=%b expected=1", done);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule